// File: doc/BRIEF.md
# Predicated Halfword Gather Loader

This block performs one predicated gather of unsigned 16-bit values into a vector of `VL_BITS` bits. The vector is split into lanes of 32 or 64 bits, chosen by a mode input. Each lane holds its own base address. A shared 64-bit offset is added to every base. A predicate with one bit per vector byte decides which lanes take part.

A `start` pulse latches the operands. The block then visits the active lanes from the lowest index upward. For each active lane it sends one read request on a simple valid/ready port and waits for a single-cycle response. It stores the returned halfword zero-extended into that lane. Lanes that are not active stay zero and cause no traffic. A one-cycle `done` marks completion. After that, `result` holds the assembled vector until the next accepted start.

Top module: `gather_hw_loader`

## Requirements
- R1: With `elem64`=0 the result is `VL_BITS/32` lanes of 32 bits, lane e at bits [e*32+31:e*32]. With `elem64`=1 it is `VL_BITS/64` lanes of 64 bits, lane e at bits [e*64+63:e*64].
- R2: Lane e is active exactly when predicate bit e*4 (32-bit lanes) or e*8 (64-bit lanes) is 1. All other predicate bits have no effect.
- R3: An inactive lane issues no read, and its result field is all zeros. Every active lane issues exactly one read.
- R4: The read address of an active lane is its base field zero-extended to 64 bits plus the offset, wrapping modulo 2^64, with no scaling.
- R5: When `off_idx` equals 31 the offset is zero, whatever `off_val` holds. Any other value of `off_idx` selects `off_val`.
- R6: The returned 16-bit value is placed in bits [15:0] of its lane, and all upper bits of the lane are zero.
- R7: Reads are issued in ascending lane order.
- R8: At most one read is outstanding, from the request handshake until `rsp_valid`. A request that is not accepted keeps `req_valid` high and `req_addr` unchanged.
- R9: If no lane is active, `done` is high in the cycle after the start, no read is issued, and `result` is all zeros.
- R10: `done` is high for exactly one cycle, and `busy` is low while it is high. `result` does not change while the block is idle and `start` is low.
- R11: A `start` that arrives while `busy` is high is ignored. This includes the cycle in which the last response arrives.
- R12: After reset, `busy`, `done` and `req_valid` are 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a gather; accepted only when idle |
| elem64 | input | 1 | Lane size: 0 = 32-bit, 1 = 64-bit |
| pred | input | VL_BITS/8 | Predicate, one bit per vector byte |
| base_vec | input | VL_BITS | Per-lane base addresses |
| off_idx | input | 5 | Offset register index; 31 means zero offset |
| off_val | input | 64 | Offset value |
| busy | output | 1 | A gather is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | VL_BITS | Assembled result vector |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | 64 | Read byte address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 16 | Read data |

## Verification
Two events can land on the same clock edge: the response for the last active lane, which finishes the gather, and a new `start` pulse. Because the gather is still busy on that edge, the start must be dropped. The bench's memory responder raises `start`, with different operands, in exactly the cycle it returns the final halfword. The scoreboard then expects the first gather's result, a single `done`, and no further read addresses. Starts raised in the middle of a gather are checked in the same way.

// File: rtl/gather_pkg.sv
package gather_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_REQ   = 2'd2,
    ST_WAIT  = 2'd3
  } gstate_e;

  localparam logic [4:0] ZERO_OFF_IDX = 5'd31;
endpackage

// File: rtl/gather_lane_mask.sv
module gather_lane_mask #(
  parameter int VL_BITS = 256,
  localparam int PW    = VL_BITS / 8,
  localparam int NLANE = VL_BITS / 32
) (
  input  logic             elem64,
  input  logic [PW-1:0]    pred,
  output logic [NLANE-1:0] active
);
  logic unused_pred_bits;
  assign unused_pred_bits = ^pred;

  for (genvar e = 0; e < NLANE; e++) begin : g_lane
    if (e < NLANE / 2) begin : g_both
      assign active[e] = elem64 ? pred[e*8] : pred[e*4];
    end else begin : g_narrow
      assign active[e] = elem64 ? 1'b0 : pred[e*4];
    end
  end
endmodule

// File: rtl/gather_lane_pick.sv
module gather_lane_pick #(
  parameter int NLANE = 8,
  localparam int IW   = (NLANE > 1) ? $clog2(NLANE) : 1
) (
  input  logic [NLANE-1:0] pend,
  output logic             any,
  output logic [IW-1:0]    idx
);
  always_comb begin
    idx = '0;
    for (int i = NLANE - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
  end
  assign any = |pend;
endmodule

// File: rtl/gather_addr_gen.sv
module gather_addr_gen #(
  parameter int VL_BITS = 256,
  localparam int NLANE  = VL_BITS / 32,
  localparam int NWIDE  = VL_BITS / 64,
  localparam int IW     = (NLANE > 1) ? $clog2(NLANE) : 1,
  localparam int HW     = (NWIDE > 1) ? $clog2(NWIDE) : 1
) (
  input  logic [VL_BITS-1:0] base_vec,
  input  logic               elem64,
  input  logic [IW-1:0]      idx,
  input  logic [63:0]        offset,
  output logic [63:0]        addr
);
  logic [31:0] lane32 [NLANE];
  logic [63:0] lane64 [NWIDE];
  logic [63:0] base_sel;

  for (genvar e = 0; e < NLANE; e++) begin : g_n
    assign lane32[e] = base_vec[e*32 +: 32];
  end
  for (genvar e = 0; e < NWIDE; e++) begin : g_w
    assign lane64[e] = base_vec[e*64 +: 64];
  end

  assign base_sel = elem64 ? lane64[idx[HW-1:0]] : {32'd0, lane32[idx]};
  assign addr     = base_sel + offset;
endmodule

// File: rtl/gather_hw_loader.sv
module gather_hw_loader
  import gather_pkg::*;
#(
  parameter int VL_BITS = 256,
  localparam int PW     = VL_BITS / 8,
  localparam int NLANE  = VL_BITS / 32,
  localparam int NWIDE  = VL_BITS / 64,
  localparam int IW     = (NLANE > 1) ? $clog2(NLANE) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               elem64,
  input  logic [PW-1:0]      pred,
  input  logic [VL_BITS-1:0] base_vec,
  input  logic [4:0]         off_idx,
  input  logic [63:0]        off_val,
  output logic               busy,
  output logic               done,
  output logic [VL_BITS-1:0] result,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [63:0]        req_addr,
  input  logic               rsp_valid,
  input  logic [15:0]        rsp_data
);
  gstate_e            state;
  logic               mode64_q;
  logic [VL_BITS-1:0] base_q;
  logic [63:0]        off_q;
  logic [NLANE-1:0]   pend;
  logic [IW-1:0]      cur_q;

  logic [NLANE-1:0]   act_in;
  logic               pick_any;
  logic [IW-1:0]      pick_idx;
  logic [63:0]        lane_addr;
  logic [NLANE-1:0]   pend_after;

  gather_lane_mask #(.VL_BITS(VL_BITS)) u_mask (
    .elem64 (elem64),
    .pred   (pred),
    .active (act_in)
  );

  gather_lane_pick #(.NLANE(NLANE)) u_pick (
    .pend (pend),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  gather_addr_gen #(.VL_BITS(VL_BITS)) u_addr (
    .base_vec (base_q),
    .elem64   (mode64_q),
    .idx      (pick_idx),
    .offset   (off_q),
    .addr     (lane_addr)
  );

  assign pend_after = pend & ~(NLANE'(1) << cur_q);
  assign busy       = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mode64_q  <= 1'b0;
      base_q    <= '0;
      off_q     <= '0;
      pend      <= '0;
      cur_q     <= '0;
      req_valid <= 1'b0;
      req_addr  <= '0;
      done      <= 1'b0;
      result    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            result <= '0;
            if (|act_in) begin
              mode64_q <= elem64;
              base_q   <= base_vec;
              off_q    <= (off_idx == ZERO_OFF_IDX) ? 64'd0 : off_val;
              pend     <= act_in;
              state    <= ST_ISSUE;
            end else begin
              done <= 1'b1;
            end
          end
        end
        ST_ISSUE: begin
          if (pick_any) begin
            cur_q     <= pick_idx;
            req_addr  <= lane_addr;
            req_valid <= 1'b1;
            state     <= ST_REQ;
          end else begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_REQ: begin
          if (req_ready) begin
            req_valid <= 1'b0;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            for (int e = 0; e < NLANE; e++) begin
              if (!mode64_q && cur_q == IW'(e))
                result[e*32 +: 32] <= {16'd0, rsp_data};
            end
            for (int e = 0; e < NWIDE; e++) begin
              if (mode64_q && cur_q == IW'(e))
                result[e*64 +: 64] <= {48'd0, rsp_data};
            end
            pend <= pend_after;
            if (pend_after == '0) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gather_hw_loader_chk.sv
module gather_hw_loader_chk #(
  parameter int VL_BITS = 256
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               req_valid,
  input logic               req_ready,
  input logic [63:0]        req_addr,
  input logic               rsp_valid,
  input logic [VL_BITS-1:0] result
);
  logic outstanding;

  always_ff @(posedge clk) begin
    if (rst) outstanding <= 1'b0;
    else if (req_valid && req_ready) outstanding <= 1'b1;
    else if (rsp_valid) outstanding <= 1'b0;
  end

  p_single_read_r8: assert property (@(posedge clk) disable iff (rst)
    outstanding |-> !req_valid);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(result));

  p_idle_no_req_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !req_valid);
endmodule

bind gather_hw_loader gather_hw_loader_chk #(.VL_BITS(VL_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .result    (result)
);

// File: tb/gather_hw_loader_bench.sv
module gather_hw_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VL = 256;
  localparam int PW = VL / 8;

  logic          clk = 0;
  logic          rst = 1;
  logic          start = 0;
  logic          elem64 = 0;
  logic [PW-1:0] pred = '0;
  logic [VL-1:0] base_vec = '0;
  logic [4:0]    off_idx = '0;
  logic [63:0]   off_val = '0;
  logic          busy, done, req_valid;
  logic [VL-1:0] result;
  logic          req_ready = 0;
  logic [63:0]   req_addr;
  logic          rsp_valid = 0;
  logic [15:0]   rsp_data = '0;

  gather_hw_loader #(.VL_BITS(VL)) u_gather_hw_loader (
    .clk(clk), .rst(rst), .start(start), .elem64(elem64), .pred(pred),
    .base_vec(base_vec), .off_idx(off_idx), .off_val(off_val),
    .busy(busy), .done(done), .result(result),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int done_cnt = 0;
  int rem_rsp = 0;
  int lat = 1;
  int stall = 0;
  int cyc = 0;
  bit poke_last = 0;
  bit poke_clear = 0;
  logic [63:0]   addr_q[$];
  logic [VL-1:0] res_q[$];
  string cur_tag = "";

  task automatic chk(input bit ok, input string msg,
                     input logic [VL-1:0] act, input logic [VL-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", msg, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_hw(input logic [63:0] a);
    return a[15:0] ^ a[31:16] ^ a[47:32] ^ a[63:48] ^ 16'h8C35;
  endfunction

  // Memory responder: records accepted requests, answers after lat cycles.
  initial begin
    bit          hs_prev = 0;
    logic [63:0] a_prev = '0;
    int          cnt = 0;
    forever begin
      @(negedge clk);
      cyc++;
      rsp_valid = 0;
      if (poke_clear) begin start = 0; poke_clear = 0; end
      if (hs_prev) begin
        if (addr_q.size() == 0)
          chk(0, {"R3 unexpected read ", cur_tag}, VL'(a_prev), '0);
        else begin
          logic [63:0] ea;
          ea = addr_q.pop_front();
          chk(a_prev == ea, {"R4/R7 read address ", cur_tag}, VL'(a_prev), VL'(ea));
        end
        cnt = lat;
      end else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          rsp_valid = 1;
          rsp_data  = mem_hw(a_prev);
          if (rem_rsp == 1 && poke_last) begin
            start = 1; pred = '1; elem64 = ~elem64; base_vec = ~base_vec;
            poke_clear = 1;
          end
          rem_rsp--;
        end
      end
      req_ready = (stall == 0) ? 1'b1 : ((cyc % 3) != 1);
      hs_prev = req_valid && req_ready;
      if (hs_prev) a_prev = req_addr;
    end
  end

  // Result monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && done) begin
        done_cnt++;
        if (res_q.size() == 0)
          chk(0, {"R11 unexpected done ", cur_tag}, result, '0);
        else begin
          logic [VL-1:0] er;
          er = res_q.pop_front();
          chk(result == er, {"R1/R3/R6 result ", cur_tag}, result, er);
        end
      end
    end
  end

  // poke: 0 none, 1 start mid-run, 2 start on last response
  task automatic run_op(input logic m64, input logic [PW-1:0] p,
                        input logic [VL-1:0] b, input logic [4:0] oi,
                        input logic [63:0] ov, input int poke, input string tag);
    int esz, nl, act_n, d0;
    logic [VL-1:0] er;
    logic [63:0] lb, a;
    esz = m64 ? 64 : 32;
    nl = VL / esz;
    er = '0;
    act_n = 0;
    for (int e = 0; e < nl; e++) begin
      if (p[e*(esz/8)]) begin
        lb = m64 ? b[e*64 +: 64] : {32'd0, b[e*32 +: 32]};
        a = lb + ((oi == 5'd31) ? 64'd0 : ov);
        addr_q.push_back(a);
        if (m64) er[e*64 +: 64] = {48'd0, mem_hw(a)};
        else     er[e*32 +: 32] = {16'd0, mem_hw(a)};
        act_n++;
      end
    end
    res_q.push_back(er);
    cur_tag = tag;
    rem_rsp = act_n;
    poke_last = (poke == 2);
    d0 = done_cnt;
    @(negedge clk);
    elem64 = m64; pred = p; base_vec = b; off_idx = oi; off_val = ov;
    start = 1;
    @(negedge clk);
    start = 0;
    if (act_n == 0) begin
      chk(done == 1'b1, {"R9 done next cycle ", tag}, VL'(done), VL'(1));
      chk(result == '0, {"R9 zero result ", tag}, result, '0);
    end else if (poke == 1) begin
      repeat (2) @(negedge clk);
      pred = '1; elem64 = ~m64; base_vec = ~b; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (done_cnt == d0) @(negedge clk);
    @(negedge clk);
    chk(done == 1'b0, {"R10 done one cycle ", tag}, VL'(done), '0);
    chk(busy == 1'b0, {"R11 idle after done ", tag}, VL'(busy), '0);
    repeat (4) @(negedge clk);
    chk(result == er, {"R10 result held ", tag}, result, er);
    chk(addr_q.size() == 0, {"R3 read count ", tag}, VL'(addr_q.size()), '0);
    chk(done_cnt == d0 + 1, {"R11 single completion ", tag}, VL'(done_cnt - d0), VL'(1));
    poke_last = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [VL-1:0] b;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !done && !req_valid, "R12 reset controls", VL'({busy, done, req_valid}), '0);
    chk(result == '0, "R12 reset result", result, '0);

    for (int e = 0; e < VL/32; e++) b[e*32 +: 32] = 32'h1000_0000 + e * 32'h0011_0370;
    run_op(0, '1, b, 5'd3, 64'h100, 0, "R1 R7 narrow all active");
    stall = 1; lat = 3;
    run_op(0, 32'hE0E0_1011, b, 5'd3, 64'h4_0000_0002, 0, "R2 R3 narrow sparse");
    for (int e = 0; e < VL/64; e++) b[e*64 +: 64] = 64'hA000_0000_0000_0000 + e * 64'h0000_1234_5678_9AB0;
    run_op(1, 32'h0001_0110, b, 5'd7, 64'h40, 0, "R1 R2 wide sparse");
    run_op(1, '1, b, 5'd31, 64'hDEAD_BEEF, 0, "R5 zero offset");
    b[63:0] = 64'hFFFF_FFFF_FFFF_FFF0;
    run_op(1, 32'h0000_0101, b, 5'd0, 64'h20, 0, "R4 wrap");
    b[31:0] = 32'hFFFF_FFF0; b[63:32] = 32'h8000_FFFF;
    run_op(0, 32'h0000_0011, b, 5'd1, 64'h20, 0, "R4 R6 zero-extend");
    run_op(1, 32'h7E7E_7E7E, b, 5'd2, 64'h99, 0, "R9 none active wide");
    run_op(0, '0, b, 5'd2, 64'h99, 0, "R9 none active narrow");
    stall = 0; lat = 1;
    run_op(0, 32'h1111_0101, b, 5'd4, 64'h8, 1, "R11 start mid-run");
    lat = 2;
    run_op(1, 32'h0101_0101, b, 5'd5, 64'h10, 2, "R11 start on last response");
    run_op(0, 32'h0000_1000, b, 5'd5, 64'h10, 0, "R11 next start accepted");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule